// File: doc/BRIEF.md
# Strap-Sampled Debug Test-Point Multiplexer

This block owns an eight-line debug observation bus. After a system reset, or after a rising edge on the park/enable input, the lines are kept in high impedance. During that time the four lowest lines are read as a mode-selection strap. The park/enable input passes through a two-flop synchronizer. A cycle counter then waits a fixed 1.5 µs, and the strap is captured into the active mode register. From the next clock the block drives all eight lines according to that mode.

Three codes are defined. The quiet code drives every line low. The clock-debug code pins the two outer lines high and puts six internal clocks, each divided down, on the middle lines. The calibration code puts eight internal timing events on the lines in a fixed order. Software can replace the mode at any time after capture through a small write port. The block reports the active code and a sticky flag that shows whether software set it.

Top module: `probe_mux`

## Requirements
- R1: While reset is asserted, tpOut and tpOe are all zero, regMode is 0000 and regFromSw is 0.
- R2: After reset is released, the strap on tpIn[3:0] is captured at the DELAY_CYC-th rising clock edge, where DELAY_CYC is 1.5 µs in clock cycles (375 at 250 MHz). tpOe becomes all ones one edge later, and stays all zero before that.
- R3: A rising edge on parkEn, seen through a two-flop synchronizer, drops tpOe to zero at the fourth clock edge after the change. It restarts the delay, and tpOe returns to all ones DELAY_CYC+4 edges after the change. A falling edge on parkEn has no effect.
- R4: The captured mode equals tpIn[3:0] at the capture edge. Changes on tpIn after capture have no effect.
- R5: Code 0000 drives all eight lines low, whatever the tap and event inputs do.
- R6: Code 0101 drives tpOut[0] and tpOut[7] high. Each tpOut[i+1], for i from 0 to 5, is bit DIV_BITS-1 of a counter of rising edges of tapSrc[i] (sampled by clk, counters cleared only by reset), registered once more.
- R7: Code 1000 drives tpOut[i] = calSig[i] with one cycle of latency. The line order is vertical sync, delayed wheel index, sequence index, spoke marker, revolution marker, auxiliary bits 0 to 2.
- R8: Any other code, from the strap or from software, drives all lines low. regMode still shows that code.
- R9: After capture, a regWe pulse loads regWdata into the mode on the next edge and sets regFromSw. tpOut follows the new mode one edge later.
- R10: A regWe pulse while the lines are tri-stated (before capture) is ignored.
- R11: regFromSw is cleared by reset and by a parkEn rising edge. A strap capture leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| parkEn | input | 1 | Asynchronous park/enable level; its rising edge restarts strap sampling |
| tpIn | input | 4 | Pad read-back of the four lowest test lines (strap) |
| tapSrc | input | 6 | Internal clocks to be divided onto lines 1 to 6 in clock-debug mode |
| calSig | input | 8 | Internal timing events for calibration mode, one per line |
| regWe | input | 1 | Software mode write strobe |
| regWdata | input | 4 | Software mode code |
| tpOut | output | 8 | Test-line output values |
| tpOe | output | 8 | Per-line output enable |
| regMode | output | 4 | Active mode code |
| regFromSw | output | 1 | Sticky flag: active mode was written by software |

## Verification
If the delay counter is off by one or the synchronizer depth is wrong, tpOe rises a cycle early or late. The bench measures that cycle exactly, after reset and after a park edge. If the mode register is loaded with the wrong value, or a write slips through while the lines are tri-stated, regMode shows it one edge later and tpOut two edges later. A fault in a tap divider shows on its line within a few tap edges. The bench compares every cycle of random tap and event traffic against its own model.

// File: rtl/probe_pkg.sv
package probe_pkg;
  localparam int TP_W  = 8;
  localparam int TAP_N = TP_W - 2;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] CODE_QUIET  = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_CLKDBG = 4'b0101;
  localparam logic [CODE_W-1:0] CODE_CAL    = 4'b1000;

  typedef struct packed {
    logic              driveEn;
    logic [CODE_W-1:0] mode;
  } pathCtl_t;
endpackage

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_pkg::*;
#(
  parameter int DELAY_CYC = 375
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parkEn,
  input  logic [CODE_W-1:0] strapIn,
  input  logic              regWe,
  input  logic [CODE_W-1:0] regWdata,
  output pathCtl_t          ctl,
  output logic [CODE_W-1:0] regMode,
  output logic              regFromSw
);
  localparam int CNT_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

  logic [2:0]        parkSync;
  logic              parkRise;
  logic [CNT_W-1:0]  waitCnt;
  logic              armed;
  logic              captured;
  logic [CODE_W-1:0] mode;
  logic              fromSw;

  assign parkRise = parkSync[1] & ~parkSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parkSync <= '0;
      waitCnt  <= '0;
      armed    <= 1'b1;
      captured <= 1'b0;
      mode     <= CODE_QUIET;
      fromSw   <= 1'b0;
    end else begin
      parkSync <= {parkSync[1:0], parkEn};
      if (parkRise) begin
        waitCnt  <= '0;
        armed    <= 1'b1;
        captured <= 1'b0;
        mode     <= CODE_QUIET;
        fromSw   <= 1'b0;
      end else if (armed) begin
        if (waitCnt == LAST) begin
          armed    <= 1'b0;
          captured <= 1'b1;
          mode     <= strapIn;
        end else begin
          waitCnt <= waitCnt + 1'b1;
        end
      end else if (captured && regWe) begin
        mode   <= regWdata;
        fromSw <= 1'b1;
      end
    end
  end

  assign ctl.driveEn = captured;
  assign ctl.mode    = mode;
  assign regMode     = mode;
  assign regFromSw   = fromSw;

  // R4
  strap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(captured) |-> (mode == $past(strapIn)) && !fromSw);

  // R10
  early_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!captured && regWe) |=> !fromSw);

  // R9
  sw_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (captured && regWe && !parkRise) |=> (mode == $past(regWdata)) && fromSw);

  // R3
  park_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    parkRise |=> !captured && !fromSw);
endmodule

// File: rtl/probe_path.sv
module probe_path
  import probe_pkg::*;
#(
  parameter int DIV_BITS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtl_t         ctl,
  input  logic [TAP_N-1:0] tapSrc,
  input  logic [TP_W-1:0]  calSig,
  output logic [TP_W-1:0]  tpOut,
  output logic [TP_W-1:0]  tpOe
);
  logic [TAP_N-1:0] tapQ;
  logic [TAP_N-1:0] tapDiv;
  logic [TP_W-1:0]  nextOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tapQ <= '0;
    else       tapQ <= tapSrc;
  end

  for (genvar i = 0; i < TAP_N; i++) begin : g_div
    logic [DIV_BITS-1:0] divCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        divCnt <= '0;
      else if (tapSrc[i] && !tapQ[i])   divCnt <= divCnt + 1'b1;
    end
    assign tapDiv[i] = divCnt[DIV_BITS-1];
  end

  always_comb begin
    nextOut = '0;
    if (ctl.driveEn) begin
      case (ctl.mode)
        CODE_CLKDBG: nextOut = {1'b1, tapDiv, 1'b1};
        CODE_CAL:    nextOut = calSig;
        default:     nextOut = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tpOut <= '0;
      tpOe  <= '0;
    end else begin
      tpOut <= nextOut;
      tpOe  <= {TP_W{ctl.driveEn}};
    end
  end

  // R2
  oe_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tpOe == '0) || (tpOe == '1));

  // R2
  tristate_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.driveEn |=> (tpOe == '0) && (tpOut == '0));

  // R5
  quiet_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == CODE_QUIET) |=> tpOut == '0);

  // R6
  clkdbg_rails_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.driveEn && ctl.mode == CODE_CLKDBG) |=> tpOut[0] && tpOut[TP_W-1]);
endmodule

// File: rtl/probe_mux.sv
module probe_mux
  import probe_pkg::*;
#(
  parameter int CLK_MHZ        = 250,
  parameter int STRAP_DELAY_NS = 1500,
  parameter int DIV_BITS       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             parkEn,
  input  logic [3:0]       tpIn,
  input  logic [5:0]       tapSrc,
  input  logic [7:0]       calSig,
  input  logic             regWe,
  input  logic [3:0]       regWdata,
  output logic [7:0]       tpOut,
  output logic [7:0]       tpOe,
  output logic [3:0]       regMode,
  output logic             regFromSw
);
  localparam int DELAY_CYC = (CLK_MHZ * STRAP_DELAY_NS + 999) / 1000;

  pathCtl_t ctl;

  probe_ctrl #(.DELAY_CYC(DELAY_CYC)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .parkEn   (parkEn),
    .strapIn  (tpIn),
    .regWe    (regWe),
    .regWdata (regWdata),
    .ctl      (ctl),
    .regMode  (regMode),
    .regFromSw(regFromSw)
  );

  probe_path #(.DIV_BITS(DIV_BITS)) u_path (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .tapSrc(tapSrc),
    .calSig(calSig),
    .tpOut (tpOut),
    .tpOe  (tpOe)
  );
endmodule

// File: tb/probe_mux_bench.sv
module probe_mux_bench;
  localparam int EXP_DELAY = 375;  // 1.5 us at 250 MHz

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       parkEn = 1'b0;
  logic [3:0] tpIn = 4'b0000;
  logic [5:0] tapSrc = '0;
  logic [7:0] calSig = '0;
  logic       regWe = 1'b0;
  logic [3:0] regWdata = '0;
  logic [7:0] tpOut, tpOe;
  logic [3:0] regMode;
  logic       regFromSw;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  int   divModel [6];
  logic [5:0] prevSrc = '0;

  always #2 clk = ~clk;

  probe_mux u_probe_mux (
    .clk(clk), .rstN(rstN), .parkEn(parkEn), .tpIn(tpIn), .tapSrc(tapSrc),
    .calSig(calSig), .regWe(regWe), .regWdata(regWdata), .tpOut(tpOut),
    .tpOe(tpOe), .regMode(regMode), .regFromSw(regFromSw)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expOut(input logic [3:0] m, input logic [7:0] cal);
    logic [7:0] v;
    v = '0;
    if (m == 4'b0101) begin
      v[0] = 1'b1;
      v[7] = 1'b1;
      for (int i = 0; i < 6; i++) v[i+1] = divModel[i][1];
    end else if (m == 4'b1000) begin
      v = cal;
    end
    return v;
  endfunction

  task automatic modelTaps(input logic [5:0] s);
    for (int i = 0; i < 6; i++)
      if (s[i] && !prevSrc[i]) divModel[i] = (divModel[i] + 1) % 4;
    prevSrc = s;
  endtask

  task automatic doReset(input logic [3:0] strap);
    @(negedge clk);
    rstN = 1'b0;
    tpIn = strap;
    for (int i = 0; i < 6; i++) divModel[i] = 0;
    prevSrc = tapSrc;
    @(negedge clk);
    // R1 reset state
    chk(tpOut == 8'h00 && tpOe == 8'h00, "R1 outputs in reset", {tpOe, tpOut}, 32'h0);
    chk(regMode == 4'h0 && !regFromSw, "R1 regs in reset", {regFromSw, regMode}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitOe(input int expN, input string req);
    int n;
    n = 0;
    while (tpOe != 8'hFF && n < 2000) begin
      @(negedge clk);
      n++;
      if (n == expN - 1) chk(tpOe == 8'h00, req, tpOe, 32'h0);
    end
    chk(n == expN, req, n, expN);
  endtask

  task automatic swWrite(input logic [3:0] code);
    @(negedge clk);
    regWe = 1'b1;
    regWdata = code;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pending;
    void'($urandom(32'd7351));

    // R2 capture timing from reset, calibration strap
    doReset(4'b1000);
    waitOe(EXP_DELAY + 1, "R2 delay after reset");
    chk(regMode == 4'b1000 && !regFromSw, "R11 strap mode, flag clear", {regFromSw, regMode}, 32'h8);

    // R4 strap pins changing after capture are ignored; R7 calibration routing
    tpIn = 4'b0101;
    pending = expOut(4'b1000, calSig);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk(tpOut == pending, "R7 calibration lines", tpOut, pending);
      calSig = 8'($urandom);
      pending = calSig;
    end
    chk(regMode == 4'b1000, "R4 strap change after capture ignored", regMode, 32'h8);

    // R9 software write to clock debug; R6 divided taps
    swWrite(4'b0101);
    chk(regMode == 4'b0101 && regFromSw, "R9 write loads mode and flag", {regFromSw, regMode}, 32'h15);
    @(negedge clk);
    pending = expOut(4'b0101, calSig);
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      chk(tpOut == pending, "R6 clock debug lines", tpOut, pending);
      pending = expOut(4'b0101, calSig);
      tapSrc = 6'($urandom);
      modelTaps(tapSrc);
    end
    @(negedge clk);
    tapSrc = '0;
    modelTaps(tapSrc);
    @(negedge clk);

    // R8 R5 R9 random software codes
    calSig = 8'h5A;
    for (int k = 0; k < 30; k++) begin
      logic [3:0] code;
      case (k % 4)
        0: code = 4'b0000;
        1: code = 4'b1000;
        2: code = 4'b0101;
        default: code = 4'($urandom);
      endcase
      swWrite(code);
      chk(regMode == code && regFromSw, "R9 random write visible", {regFromSw, regMode}, {27'h0, 1'b1, code});
      @(negedge clk);
      pending = expOut(code, calSig);
      chk(tpOut == pending, (code == 4'b0000) ? "R5 quiet code" : "R8 code routing", tpOut, pending);
    end

    // R3 park rising edge, R10 early write ignored
    swWrite(4'b1000);
    @(negedge clk);
    tpIn = 4'b0101;
    parkEn = 1'b1;
    begin
      int n;
      n = 0;
      repeat (3) begin @(negedge clk); n++; end
      chk(tpOe == 8'hFF, "R3 oe held through synchronizer", tpOe, 32'hFF);
      @(negedge clk); n++;
      chk(tpOe == 8'h00 && tpOut == 8'h00, "R3 oe drops after park edge", {tpOe, tpOut}, 32'h0);
      regWe = 1'b1; regWdata = 4'b1000;
      @(negedge clk); n++;
      regWe = 1'b0;
      chk(!regFromSw, "R10 write during wait ignored", regFromSw, 32'h0);
      while (tpOe != 8'hFF && n < 2000) begin @(negedge clk); n++; end
      chk(n == EXP_DELAY + 4, "R3 recapture timing", n, EXP_DELAY + 4);
    end
    chk(regMode == 4'b0101 && !regFromSw, "R10 R11 strap mode after recapture", {regFromSw, regMode}, 32'h5);
    parkEn = 1'b0;
    repeat (10) @(negedge clk);
    chk(tpOe == 8'hFF && regMode == 4'b0101, "R3 falling park edge no effect", {tpOe, 4'h0, regMode}, 32'hFF05);

    // R8 undefined strap code
    calSig = 8'hC3;
    doReset(4'b0011);
    waitOe(EXP_DELAY + 1, "R2 delay after reset (undefined strap)");
    @(negedge clk);
    chk(regMode == 4'b0011 && tpOut == 8'h00, "R8 undefined strap drives low", {regMode, tpOut}, 32'h300);

    // R5 quiet strap with busy taps and events
    doReset(4'b0000);
    waitOe(EXP_DELAY + 1, "R2 delay after reset (quiet strap)");
    for (int k = 0; k < 20; k++) begin
      tapSrc = 6'($urandom);
      calSig = 8'($urandom);
      @(negedge clk);
      chk(tpOut == 8'h00 && tpOe == 8'hFF, "R5 quiet strap stays low", {tpOe, tpOut}, 32'hFF00);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule